// File: doc/BRIEF.md
# Four-Channel Countdown Event Timer

This block is a bank of four independent countdown timers behind one 32-bit register bus. One shared control word holds, for every channel, a run enable, a periodic/one-shot choice and a two-bit timebase select; each channel also has its own count register. A tick generator divides the system clock into a 1 us strobe and then, through three chained divide-by-ten stages, into 10 us, 100 us and 1 ms strobes.

An enabled channel steps its count down by one on each strobe of its selected timebase. A tick that finds the count at zero is an expiry. The channel then raises a one-cycle interrupt pulse on its own line. In periodic mode it reloads, so a reload value N gives exactly one expiry every N+1 ticks. In one-shot mode it stops and clears its own enable bit in hardware.

Software uses a channel by writing the reload value while the channel is stopped and then setting the enable bit. A periodic tick source is set up by writing (ticks per period - 1), so 9999 at the 1 us timebase gives 10 ms. A single programmed delay is set up in one-shot mode with any value from 1 to 0xFFFE.

Top module: `quad_timer`

## Requirements
- R1: After synchronous reset every register reads 0 and all four interrupt outputs are low.
- R2: Register map, for word-aligned byte addresses. The control word is at 0x00. It holds the run enable of channel k (A=0, B=1, C=2, D=3) in bit 16+k, the mode of channel k in bit 12+k (1 = periodic, 0 = one-shot) and the timebase of channel k in bits 2k+1:2k. All other control bits read 0. The count registers of channels A, B, C and D are at 0x04, 0x08, 0x0C and 0x10. A count register reads back the live count in bits 15:0, with the upper bits 0.
- R3: Timebase code 0 selects 1 us, 1 selects 10 us, 2 selects 100 us and 3 selects 1 ms, where 1 us is CYCLES_PER_US clock cycles. Counting edges after reset release from 0, the 1 us strobe falls on edge k when k mod CYCLES_PER_US = CYCLES_PER_US-1, and the 10^d us strobe falls on edge k when k mod (10^d * CYCLES_PER_US) equals that modulus minus 1.
- R4: When an enabled channel sees a strobe of its timebase while its count is 0, it expires. Its interrupt output is high for exactly the one cycle after that clock edge.
- R5: In periodic mode an expiry reloads the count from the reload value, and any other selected strobe lowers the count by one. Reload value N gives expiries exactly (N+1) ticks apart.
- R6: In one-shot mode an expiry clears the channel's enable bit in hardware. The count stays at 0 and no further interrupt follows.
- R7: A count-register write always sets the reload value. It also sets the live count only while the channel is disabled; on an enabled channel the live count is unchanged and the new value takes effect at the next reload.
- R8: A control write that raises a channel's enable from 0 to 1 restarts its count from the reload value. A disabled channel holds its count.
- R9: Writes to unused or misaligned addresses (low address bits not 00, or offsets 0x14 to 0x1C) change nothing, and such addresses read 0. Count values up to 0xFFFE are stored exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 4 | Per-channel expiry pulse, bit k = channel k |

## Verification
Read data is due in the same cycle as the address, and a write shows in the read data in the cycle after the clock edge that takes it. An interrupt is due in the cycle after the edge on which the selected strobe meets a zero count, and the strobe edges are fixed from reset release by R3. The bench therefore drives inputs just after the rising edge and samples at the falling edge. Its model counts edges since reset to place every strobe, and on every clock it compares read data and the interrupt lines with the model. Directed checks measure the spacing of interrupt pulses in whole cycles: 16 for reload 3 at 1 us, 400 at 100 us and 8000 at 1 ms, with a 4-cycle microsecond.

// File: rtl/quad_timer_pkg.sv
// Shared constants and types for the four-channel countdown timer.
// Assumes a 32-bit data bus with byte addresses and word-aligned registers.
package quad_timer_pkg;
    localparam int NUM_CH   = 4;   // channels A..D
    localparam int CNT_W    = 16;  // count / reload width
    localparam int TB_W     = 2;   // timebase select width
    localparam int NUM_TB   = 4;   // 1us, 10us, 100us, 1ms
    localparam int DECADE   = 10;  // ratio between neighbouring timebases
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int EN_LSB   = 16;  // enable of channel k at EN_LSB+k
    localparam int MODE_LSB = 12;  // mode of channel k at MODE_LSB+k

    typedef enum logic [TB_W-1:0] {
        TB_1US   = 2'd0,
        TB_10US  = 2'd1,
        TB_100US = 2'd2,
        TB_1MS   = 2'd3
    } tb_sel_e;
endpackage

// File: rtl/qt_tickgen.sv
// Timebase strobe generator.
// Divides the system clock by CYCLES_PER_US into a one-cycle 1 us strobe,
// then chains decade stages so strobe[g] marks every 10^g microseconds.
// All strobes of one instant are high in the same cycle.
// Assumes CYCLES_PER_US >= 1.
module qt_tickgen #(
    parameter int CYCLES_PER_US = 200,
    parameter int NUM_TB        = 4,
    parameter int DECADE        = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [NUM_TB-1:0] strobe
);
    localparam int PW = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(CYCLES_PER_US - 1);
    localparam int DW = $clog2(DECADE);
    localparam logic [DW-1:0] D_LAST = DW'(DECADE - 1);

    logic [PW-1:0]     pre_q;
    logic              us_hit;
    logic [NUM_TB-1:1] dec_last;

    assign us_hit = (pre_q == P_LAST);

    // Clock prescaler: wraps every CYCLES_PER_US cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (us_hit) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    generate
        for (genvar g = 1; g < NUM_TB; g++) begin : g_decade
            logic [DW-1:0] dec_q;
            // Decade stage: counts strobes of the next faster timebase.
            always_ff @(posedge clk) begin
                if (!rst_n)             dec_q <= '0;
                else if (strobe[g-1])   dec_q <= (dec_q == D_LAST) ? '0 : dec_q + 1'b1;
            end
            assign dec_last[g] = (dec_q == D_LAST);
        end
    endgenerate

    // Strobe chain: each slower strobe needs the faster one and a wrapping stage.
    always_comb begin
        strobe[0] = us_hit;
        for (int g = 1; g < NUM_TB; g++) begin
            strobe[g] = strobe[g-1] && dec_last[g];
        end
    end
endmodule

// File: rtl/qt_channel.sv
// One countdown channel.
// Holds the run enable, the reload value and the live count. It counts down
// on the strobe picked by tb_sel, and expires when a strobe finds the count
// at zero. Expiry gives a one-cycle irq_o in the next cycle, then a reload
// (periodic) or a hardware clear of the enable (one-shot).
// Assumes at most one register write per cycle.
module qt_channel
    import quad_timer_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NTB = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NTB-1:0] strobe,
    input  logic [TB_W-1:0] tb_sel,
    input  logic           periodic,
    input  logic           ctrl_we,
    input  logic           en_wbit,
    input  logic           cnt_we,
    input  logic [CW-1:0]  cnt_wdata,
    output logic           en_o,
    output logic [CW-1:0]  cnt_o,
    output logic [CW-1:0]  rld_o,
    output logic           irq_o
);
    logic          en_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] rld_q;
    logic          irq_q;
    logic          tick;
    logic          expire;
    logic          restart;

    assign tick    = strobe[tb_sel];
    assign expire  = en_q && tick && (cnt_q == '0);
    assign restart = ctrl_we && en_wbit && !en_q;

    // Run enable: software write wins, otherwise one-shot expiry clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                    en_q <= 1'b0;
        else if (ctrl_we)              en_q <= en_wbit;
        else if (expire && !periodic)  en_q <= 1'b0;
    end

    // Reload value: taken from every write to this channel's count register.
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '0;
        else if (cnt_we) rld_q <= cnt_wdata;
    end

    // Live count: restart, load while stopped, or step on the selected strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (restart)            cnt_q <= rld_q;
        else if (cnt_we && !en_q)    cnt_q <= cnt_wdata;
        else if (en_q && tick) begin
            if (cnt_q == '0)         cnt_q <= periodic ? rld_q : '0;
            else                     cnt_q <= cnt_q - 1'b1;
        end
    end

    // Interrupt pulse: registered copy of the expiry condition.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= expire;
    end

    assign en_o  = en_q;
    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign irq_o = irq_q;
endmodule

// File: rtl/qt_regfile.sv
// Register decode for the timer bank.
// Decodes word-aligned byte addresses: slot 0 is the shared control word,
// slots 1..NCH are the channel count registers. Stores the mode and timebase
// fields; the enable bits live in the channels so that hardware can clear
// them. Reads are combinational. Misaligned or unused addresses read 0 and
// ignore writes.
module qt_regfile
    import quad_timer_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 5,
    parameter int DW  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    input  logic [NCH-1:0]           en_i,
    input  logic [NCH-1:0][CW-1:0]   cnt_i,
    output logic                     ctrl_we,
    output logic [NCH-1:0]           en_wbits,
    output logic [NCH-1:0]           cnt_we,
    output logic [CW-1:0]            cnt_wdata,
    output logic [NCH-1:0]           mode_o,
    output logic [NCH-1:0][TB_W-1:0] tb_o
);
    localparam int SW = AW - 2;

    logic [SW-1:0]            slot;
    logic                     aligned;
    logic [NCH-1:0]           mode_q;
    logic [NCH-1:0][TB_W-1:0] tb_q;
    logic [DW-1:0]            ctrl_img;

    assign slot      = bus_addr[AW-1:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign ctrl_we   = bus_we && aligned && (slot == '0);
    assign en_wbits  = bus_wdata[EN_LSB +: NCH];
    assign cnt_wdata = bus_wdata[CW-1:0];

    // Count-register write decode, one strobe per channel.
    always_comb begin
        for (int ch = 0; ch < NCH; ch++) begin
            cnt_we[ch] = bus_we && aligned && (slot == SW'(ch + 1));
        end
    end

    // Mode and timebase fields of the shared control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            tb_q   <= '0;
        end else if (ctrl_we) begin
            mode_q <= bus_wdata[MODE_LSB +: NCH];
            tb_q   <= bus_wdata[NCH*TB_W-1:0];
        end
    end

    // Control word image as seen by a read.
    always_comb begin
        ctrl_img = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            ctrl_img[EN_LSB + ch]         = en_i[ch];
            ctrl_img[MODE_LSB + ch]       = mode_q[ch];
            ctrl_img[TB_W*ch +: TB_W]     = tb_q[ch];
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (slot == '0) bus_rdata = ctrl_img;
            for (int ch = 0; ch < NCH; ch++) begin
                if (slot == SW'(ch + 1)) bus_rdata = {{(DW-CW){1'b0}}, cnt_i[ch]};
            end
        end
    end

    assign mode_o = mode_q;
    assign tb_o   = tb_q;
endmodule

// File: rtl/quad_timer.sv
// Four-channel countdown event timer, top level.
// Ties the tick generator, the register decode and one channel per timer.
// CYCLES_PER_US sets how many system clocks make one microsecond.
// Assumes a synchronous active-low reset held for at least two cycles.
module quad_timer
    import quad_timer_pkg::*;
#(
    parameter int CYCLES_PER_US = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);
    logic [NUM_TB-1:0]            strobe;
    logic                         ctrl_we;
    logic [NUM_CH-1:0]            en_wbits;
    logic [NUM_CH-1:0]            cnt_we;
    logic [CNT_W-1:0]             cnt_wdata;
    logic [NUM_CH-1:0]            mode_vec;
    logic [NUM_CH-1:0][TB_W-1:0]  tb_vec;
    logic [NUM_CH-1:0]            en_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_arr;
    logic [NUM_CH-1:0][CNT_W-1:0] rld_arr;

    qt_tickgen #(
        .CYCLES_PER_US (CYCLES_PER_US),
        .NUM_TB        (NUM_TB),
        .DECADE        (DECADE)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe)
    );

    qt_regfile #(
        .NCH (NUM_CH),
        .CW  (CNT_W),
        .AW  (ADDR_W),
        .DW  (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_i      (en_vec),
        .cnt_i     (cnt_arr),
        .ctrl_we   (ctrl_we),
        .en_wbits  (en_wbits),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .mode_o    (mode_vec),
        .tb_o      (tb_vec)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            qt_channel #(
                .CW  (CNT_W),
                .NTB (NUM_TB)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .strobe    (strobe),
                .tb_sel    (tb_vec[ch]),
                .periodic  (mode_vec[ch]),
                .ctrl_we   (ctrl_we),
                .en_wbit   (en_wbits[ch]),
                .cnt_we    (cnt_we[ch]),
                .cnt_wdata (cnt_wdata),
                .en_o      (en_vec[ch]),
                .cnt_o     (cnt_arr[ch]),
                .rld_o     (rld_arr[ch]),
                .irq_o     (irq_o[ch])
            );
        end
    endgenerate
endmodule

// File: rtl/qt_timer_chk.sv
// Assertion checker for quad_timer, attached by bind.
// Relates per-channel enable, count, reload and interrupt over time.
module qt_timer_chk #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0]         en,
    input logic [NCH-1:0]         mode,
    input logic                   ctrl_we,
    input logic [NCH-1:0]         cnt_we,
    input logic [NCH-1:0][CW-1:0] cnt,
    input logic [NCH-1:0][CW-1:0] rld
);
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_a
            // R4: a pulse only follows a cycle in which the channel ran.
            p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
                irq[i] |-> $past(en[i]))
                else $error("p_irq_needs_en_r4 ch%0d", i);

            // R5: periodic expiry leaves the count at the reload value.
            p_periodic_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (irq[i] && $past(mode[i]) && !$past(ctrl_we) && !$past(cnt_we[i]))
                |-> (cnt[i] == rld[i]))
                else $error("p_periodic_reload_r5 ch%0d", i);

            // R5: outside expiry and writes, a running count only steps by one.
            p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(en[i]) && !$past(ctrl_we) && !$past(cnt_we[i]) && !irq[i]
                 && !$stable(cnt[i]))
                |-> (cnt[i] == $past(cnt[i]) - 1'b1))
                else $error("p_single_step_r5 ch%0d", i);

            // R6: one-shot expiry stops the channel.
            p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (irq[i] && !$past(mode[i]) && !$past(ctrl_we)) |-> !en[i])
                else $error("p_oneshot_stop_r6 ch%0d", i);

            // R8: a stopped channel with no write holds its count.
            p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(en[i]) && !$past(ctrl_we) && !$past(cnt_we[i])) |-> $stable(cnt[i]))
                else $error("p_idle_hold_r8 ch%0d", i);
        end
    endgenerate
endmodule

bind quad_timer qt_timer_chk #(
    .NCH (quad_timer_pkg::NUM_CH),
    .CW  (quad_timer_pkg::CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq_o),
    .en      (en_vec),
    .mode    (mode_vec),
    .ctrl_we (ctrl_we),
    .cnt_we  (cnt_we),
    .cnt     (cnt_arr),
    .rld     (rld_arr)
);

// File: tb/tb_quad_timer.sv
`timescale 1ns/1ps
module tb_quad_timer;
    localparam int P     = 4;       // clocks per microsecond in this bench
    localparam int LIMIT = 100000;  // watchdog in cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int total = 0;
    int bad   = 0;
    longint tcyc = 0;

    always #2.5 clk = ~clk;

    quad_timer #(.CYCLES_PER_US(P)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_en[4], m_mode[4], m_tb[4], m_rld[4], m_cnt[4];
    logic [3:0] m_irq;
    longint cyc;
    int tk[4];
    int wslot;

    always @(posedge clk) begin
        tcyc = tcyc + 1;
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_en[c] = 0; m_mode[c] = 0; m_tb[c] = 0; m_rld[c] = 0; m_cnt[c] = 0;
            end
            m_irq = '0;
            cyc = 0;
        end else begin
            tk[0] = ((cyc % P) == P - 1);
            tk[1] = ((cyc % (10 * P)) == 10 * P - 1);
            tk[2] = ((cyc % (100 * P)) == 100 * P - 1);
            tk[3] = ((cyc % (1000 * P)) == 1000 * P - 1);
            wslot = (bus_we && bus_addr[1:0] == 2'b00) ? int'(bus_addr[4:2]) : -1;
            for (int c = 0; c < 4; c++) begin
                int hit;
                hit = (m_en[c] != 0) && (tk[m_tb[c]] != 0) && (m_cnt[c] == 0);
                m_irq[c] = (hit != 0);
                if (wslot == 0 && bus_wdata[16+c] && m_en[c] == 0) m_cnt[c] = m_rld[c];
                else if (wslot == c + 1 && m_en[c] == 0) m_cnt[c] = int'(bus_wdata[15:0]);
                else if (m_en[c] != 0 && tk[m_tb[c]] != 0)
                    m_cnt[c] = (hit != 0) ? ((m_mode[c] != 0) ? m_rld[c] : 0) : m_cnt[c] - 1;
                if (wslot == c + 1) m_rld[c] = int'(bus_wdata[15:0]);
                if (wslot == 0) m_en[c] = int'(bus_wdata[16+c]);
                else if (hit != 0 && m_mode[c] == 0) m_en[c] = 0;
            end
            if (wslot == 0) begin
                for (int c = 0; c < 4; c++) begin
                    m_mode[c] = int'(bus_wdata[12+c]);
                    m_tb[c]   = int'(bus_wdata[2*c +: 2]);
                end
            end
            cyc = cyc + 1;
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] a);
        logic [31:0] v;
        v = '0;
        if (a[1:0] == 2'b00) begin
            if (a[4:2] == 3'd0) begin
                for (int c = 0; c < 4; c++) begin
                    v[16+c] = m_en[c][0];
                    v[12+c] = m_mode[c][0];
                    v[2*c +: 2] = m_tb[c][1:0];
                end
            end else if (a[4:2] <= 3'd4) begin
                v[15:0] = m_cnt[a[4:2]-1][15:0];
            end
        end
        return v;
    endfunction

    // Every-cycle comparison against the model (R2 read data, R4 pulses).
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (irq_o !== m_irq) begin
                bad++;
                $display("FAIL R4 irq per-cycle: actual=%b expected=%b", irq_o, m_irq);
            end
            total++;
            if (bus_rdata !== m_read(bus_addr)) begin
                bad++;
                $display("FAIL R2 rdata per-cycle addr=%h: actual=%h expected=%h",
                         bus_addr, bus_rdata, m_read(bus_addr));
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (tcyc == LIMIT) begin
            total++; bad++;
            $display("FAIL R1 watchdog: actual=%0d cycles expected<%0d", tcyc, LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    // Sample right after a write, without another edge in between.
    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        peek(a, d);
    endtask

    task automatic wait_irq(input int ch, input int lim, output longint at);
        at = -1;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (irq_o[ch]) begin
                at = tcyc;
                break;
            end
        end
        total++;
        if (at < 0) begin
            bad++;
            $display("FAIL R4 no pulse on ch%0d: actual=none expected=pulse within %0d", ch, lim);
        end
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] d, d2;
        longint p1, p2, t0;
        int extra;

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            peek(5'(a * 4), d);
            chk("R1 reset read", d, 0);
        end
        chk("R1 reset irq", irq_o, 0);

        // R5/R3: channel A periodic, 1us, reload 3 -> 16-cycle spacing
        wr(5'h04, 32'd3);
        wr(5'h00, 32'h0001_1000);
        wait_irq(0, 100, p1);
        wait_irq(0, 100, p2);
        chk("R5 periodic spacing N=3 1us", p2 - p1, 16);
        @(negedge clk);
        chk("R4 one-cycle pulse", irq_o[0], 0);

        // R7: write while running changes only the reload
        wr(5'h04, 32'd7);
        @(negedge clk);
        chk("R7 live count unchanged (<=3)", (bus_rdata <= 32'd3), 1);
        wait_irq(0, 100, p1);
        wait_irq(0, 100, p2);
        chk("R7 new reload spacing", p2 - p1, 32);

        // R8: stopped channel holds, restart reloads
        wr(5'h00, 32'h0000_0000);
        peek(5'h04, d);
        repeat (20) @(posedge clk);
        #1 peek(5'h04, d2);
        chk("R8 hold while disabled", d2, d);
        wr(5'h00, 32'h0001_1000);
        peek(5'h04, d);
        chk("R8 restart from reload", d, 7);
        wr(5'h00, 32'h0000_0000);

        // R6: channel B one-shot, 10us, reload 2
        wr(5'h08, 32'd2);
        wr(5'h00, 32'h0002_0004);
        t0 = tcyc;
        wait_irq(1, 400, p1);
        chk("R6 one-shot delay in window", (p1 - t0 > 80) && (p1 - t0 <= 125), 1);
        rd(5'h00, d);
        chk("R6 enable cleared by hardware", d[17], 0);
        rd(5'h08, d);
        chk("R6 count stays 0", d, 0);
        extra = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (irq_o[1]) extra++;
        end
        chk("R6 no further pulse", extra, 0);

        // R3: D at 100us reload 0, C at 1ms reload 1
        wr(5'h0C, 32'd1);
        wr(5'h10, 32'd0);
        wr(5'h00, 32'h000C_C0B0);
        peek(5'h00, d);
        chk("R2 control readback", d, 32'h000C_C0B0);
        wait_irq(3, 1000, p1);
        wait_irq(3, 1000, p2);
        chk("R3 100us spacing", p2 - p1, 400);
        wait_irq(2, 9000, p1);
        wait_irq(2, 9000, p2);
        chk("R3 1ms spacing N=1", p2 - p1, 8000);
        wr(5'h00, 32'h0000_0000);

        // R9 / R2: widths, unused and misaligned addresses
        wr(5'h0C, 32'h0000_FFFE);
        peek(5'h0C, d);
        chk("R9 max delay stored", d, 32'h0000_FFFE);
        wr(5'h08, 32'hFFFF_FFFF);
        peek(5'h08, d);
        chk("R2 count upper bits read 0", d, 32'h0000_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        peek(5'h14, d);
        chk("R9 unused offset reads 0", d, 0);
        wr(5'h01, 32'hFFFF_FFFF);
        peek(5'h01, d);
        chk("R9 misaligned reads 0", d, 0);
        rd(5'h00, d);
        chk("R9 control untouched", d, 0);
        wr(5'h00, 32'hFFFF_FFFF);
        peek(5'h00, d);
        chk("R2 reserved control bits read 0", d, 32'h000F_F0FF);
        wr(5'h00, 32'h0000_0000);
        repeat (4) @(posedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule